// File: doc/BRIEF.md
# Programmable Waveform State Sequencer

This block plays a short, software-defined bus waveform toward an external peripheral. A static table holds up to seven active states; the index one past the last active state is the idle state. Each active state has a six-bit opcode, a dwell count and two branch targets. A start strobe launches the waveform. From then on every state decides, through its opcode, five things: whether the data bus is driven, sampled or left alone; whether the address output steps; whether the outbound FIFO moves to its next word; whether an interrupt pulse is raised; and whether the data word comes from the FIFO or from one of two 16-bit holding registers.

A waveform runs in one of four modes. It either writes or reads, and it either streams through the FIFO or moves one single word. Plain states wait a fixed number of clocks. Decision states branch on a ready input. The waveform ends when it reaches the idle index, or when a streaming transfer finds the FIFO empty (write) or full (read). At that point the block releases the bus and pulses a done flag. The data bus is split into an input, an output and an output-enable, so the pad tristate sits outside the block.

Top module: `wf_sequencer`

## Requirements
- R1: From idle, a start pulse enters state 0 on the next clock, latches the write/read and FIFO/single mode and makes `busy` high. A start while busy is ignored.
- R2: A state with `dp`=0 and dwell value d lasts d+1 clocks, then moves to the next index. Leaving state 6 reaches the idle index 7.
- R3: A state with `dp`=1 evaluates `ready` every clock and goes to its high target when `ready`=1 or its low target when `ready`=0. A target equal to the current state holds it without a new entry. A target of 7 ends the waveform.
- R4: At start, `addr` loads `adr_init`. On every state entry it then adds 1 if that state's `incad` is set, wrapping at 9 bits. It never changes at any other time.
- R5: `irq` is high for exactly the first clock of an entered state whose `gint` is set.
- R6: In a write waveform, `bus_oe` is high in every clock of a state with `data`=1, and `bus_dout` carries the selected source word. Otherwise `bus_oe` is 0 and `bus_dout` is 0.
- R7: In a read waveform, a state with `data`=1 samples `bus_din` on its final clock. The word goes to the FIFO (`fifo_push` with `fifo_wdata`) or to the selected holding capture register. With `data`=0 the bus is ignored.
- R8: In a FIFO waveform, `sgl`=1 routes the word through a holding register instead of the FIFO: the CRC register when `nxt`=1, the single-data register when `nxt`=0. In a single waveform `sgl` is ignored and the single-data register is always used, with no FIFO traffic.
- R9: In a FIFO write waveform, a state with `sgl`=0 and `nxt`=1 pulses `fifo_pop` once, on its first clock, when the FIFO is not empty. There is never a pop in a read waveform.
- R10: When the waveform reaches index 7, `busy` drops and `done` pulses for one clock.
- R11: On the first clock of a FIFO-sourced data state (FIFO mode, `sgl`=0, `data`=1), an empty FIFO in write mode or a full FIFO in read mode aborts the waveform. No bus drive and no push happen, and the next clock is idle with a `done` pulse.
- R12: Opcode bit positions: 5 `sgl`, 4 `gint`, 3 `incad`, 2 `nxt`, 1 `data`, 0 `dp`. The fields of state i sit at bits [6i+5:6i] of `op_tbl`, [8i+7:8i] of `dwell_tbl`, and [3i+2:3i] of `hi_tbl` and `lo_tbl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch strobe, honoured only when idle |
| wave_wr | input | 1 | 1 = write waveform, 0 = read waveform |
| wave_fifo | input | 1 | 1 = FIFO waveform, 0 = single-word waveform |
| adr_init | input | 9 | Address loaded at start |
| op_tbl | input | 42 | Per-state opcodes |
| dwell_tbl | input | 56 | Per-state dwell values |
| hi_tbl | input | 21 | Per-state branch target when ready is 1 |
| lo_tbl | input | 21 | Per-state branch target when ready is 0 |
| ready | input | 1 | Peripheral ready, tested by decision states |
| fifo_rdata | input | 16 | Head word of the outbound FIFO |
| fifo_empty | input | 1 | Outbound FIFO empty |
| fifo_pop | output | 1 | Advance the outbound FIFO |
| fifo_full | input | 1 | Inbound FIFO full |
| fifo_push | output | 1 | Write `fifo_wdata` into the inbound FIFO |
| fifo_wdata | output | 16 | Sampled word for the inbound FIFO |
| sgl_src | input | 16 | Single-data word for writes |
| crc_src | input | 16 | CRC word for writes |
| sgl_cap | output | 16 | Single-data word captured by reads |
| crc_cap | output | 16 | CRC word captured by reads |
| bus_din | input | 16 | Data bus input |
| bus_dout | output | 16 | Data bus output |
| bus_oe | output | 1 | Data bus output enable |
| addr | output | 9 | Peripheral address |
| irq | output | 1 | Per-state interrupt pulse |
| busy | output | 1 | Waveform in progress |
| done | output | 1 | One-clock end-of-waveform pulse |

## Verification
A wrong state index or dwell count is visible at the ports within one clock. It shifts the clock in which `irq`, `fifo_pop` or `bus_oe` change, or moves `addr`, so comparing every output against a clocked reference model on every clock finds it at once. A wrong holding-register selection or sample clock changes `sgl_cap`, `crc_cap` or the pushed word on the clock after the state's last cycle. A missed abort shows as `bus_oe` or `fifo_push` in the cycle where both should stay low. Decision-state loops that wrap back to state 0 drain or fill the FIFO, which drives both abort cases.

// File: rtl/wf_pkg.sv
package wf_pkg;

    localparam int OPW       = 6;
    localparam int INCAD_BIT = 3;

    // One opcode word; bit order is fixed (R12)
    typedef struct packed {
        logic sgl;
        logic gint;
        logic incad;
        logic nxt;
        logic data;
        logic dp;
    } wf_op_t;

    // Effective per-state controls once the waveform mode is known
    typedef struct packed {
        logic use_hold;
        logic sel_crc;
        logic drive;
        logic sample;
        logic adv;
        logic needs_fifo;
    } wf_ctl_t;

    function automatic wf_ctl_t wf_decode(logic sgl, logic nxt, logic data,
                                          logic wr, logic fifo);
        wf_ctl_t c;
        c.use_hold   = !fifo || sgl;
        c.sel_crc    = fifo && sgl && nxt;
        c.drive      = wr && data;
        c.sample     = !wr && data;
        c.adv        = fifo && !sgl && nxt && wr;
        c.needs_fifo = fifo && !sgl && data;
        return c;
    endfunction

endpackage

// File: rtl/wf_opdec.sv
module wf_opdec
    import wf_pkg::*;
#(
    parameter int NSTATE = 7,
    parameter int STW    = 3,
    parameter int CW     = 8
) (
    input  logic [STW-1:0]        cur_idx,
    input  logic [STW-1:0]        nxt_idx,
    input  logic [NSTATE*OPW-1:0] op_tbl,
    input  logic [NSTATE*CW-1:0]  dwell_tbl,
    input  logic [NSTATE*STW-1:0] hi_tbl,
    input  logic [NSTATE*STW-1:0] lo_tbl,
    output wf_op_t                cur_op,
    output logic [STW-1:0]        cur_hi,
    output logic [STW-1:0]        cur_lo,
    output logic [CW-1:0]         nxt_dwell,
    output logic                  nxt_incad
);

    // The idle index matches no entry and decodes to an all-zero state
    always_comb begin
        cur_op    = '0;
        cur_hi    = '0;
        cur_lo    = '0;
        nxt_dwell = '0;
        nxt_incad = 1'b0;
        for (int i = 0; i < NSTATE; i++) begin
            if (cur_idx == STW'(i)) begin
                cur_op = wf_op_t'(op_tbl[i*OPW +: OPW]);
                cur_hi = hi_tbl[i*STW +: STW];
                cur_lo = lo_tbl[i*STW +: STW];
            end
            if (nxt_idx == STW'(i)) begin
                nxt_dwell = dwell_tbl[i*CW +: CW];
                nxt_incad = op_tbl[i*OPW + INCAD_BIT];
            end
        end
    end

endmodule

// File: rtl/wf_seq.sv
module wf_seq #(
    parameter int NSTATE = 7,
    parameter int STW    = 3,
    parameter int CW     = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           ready,
    input  logic           cur_dp,
    input  logic [STW-1:0] cur_hi,
    input  logic [STW-1:0] cur_lo,
    input  logic [CW-1:0]  nxt_dwell,
    input  logic           abort,
    output logic [STW-1:0] state_q,
    output logic [STW-1:0] nxt_idx,
    output logic           first_q,
    output logic           leave,
    output logic           enter,
    output logic           busy,
    output logic           done_q
);

    localparam logic [STW-1:0] IDLE = STW'(NSTATE);

    logic [CW-1:0]  cnt_q;
    logic [STW-1:0] tgt;

    assign busy = (state_q != IDLE);

    always_comb begin
        tgt     = ready ? cur_hi : cur_lo;
        nxt_idx = state_q;
        leave   = 1'b0;
        if (!busy) begin
            if (start) begin
                nxt_idx = '0;
                leave   = 1'b1;
            end
        end else if (abort) begin
            nxt_idx = IDLE;
            leave   = 1'b1;
        end else if (cur_dp) begin
            if (tgt != state_q) begin
                nxt_idx = (tgt >= IDLE) ? IDLE : tgt;
                leave   = 1'b1;
            end
        end else if (cnt_q == '0) begin
            nxt_idx = state_q + 1'b1;
            leave   = 1'b1;
        end
        enter = leave && (nxt_idx != IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IDLE;
            cnt_q   <= '0;
            first_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= nxt_idx;
            first_q <= enter;
            done_q  <= busy && leave && (nxt_idx == IDLE);
            if (enter)
                cnt_q <= nxt_dwell;
            else if (busy && cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    // R1
    start_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (state_q == '0 && first_q));

    // R3
    dp_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cur_dp && !abort && tgt == state_q) |=> ($stable(state_q) && !first_q));

    // R5
    entry_new_chk: assert property (@(posedge clk) disable iff (rst)
        first_q |-> (state_q != $past(state_q)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy ##1 !done_q));

endmodule

// File: rtl/wf_dpath.sv
module wf_dpath
    import wf_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_ev,
    input  logic          enter,
    input  logic          first,
    input  logic          leave,
    input  logic          active,
    input  logic          op_sgl,
    input  logic          op_gint,
    input  logic          op_incad,
    input  logic          op_nxt,
    input  logic          op_data,
    input  logic          nxt_incad,
    input  logic          wave_wr,
    input  logic          wave_fifo,
    input  logic [AW-1:0] adr_init,
    input  logic [DW-1:0] fifo_rdata,
    input  logic          fifo_empty,
    input  logic          fifo_full,
    input  logic [DW-1:0] sgl_src,
    input  logic [DW-1:0] crc_src,
    input  logic [DW-1:0] bus_din,
    output logic          abort,
    output logic          bus_oe,
    output logic [DW-1:0] bus_dout,
    output logic          fifo_pop,
    output logic          fifo_push,
    output logic [DW-1:0] fifo_wdata,
    output logic [DW-1:0] sgl_cap,
    output logic [DW-1:0] crc_cap,
    output logic [AW-1:0] addr,
    output logic          irq
);

    logic    wr_q, fifo_q, take;
    wf_ctl_t ctl;

    assign ctl   = wf_decode(op_sgl, op_nxt, op_data, wr_q, fifo_q);
    assign abort = first && ctl.needs_fifo && (wr_q ? fifo_empty : fifo_full);
    assign take  = active && leave && !abort && ctl.sample;

    assign irq        = first && op_gint;
    assign bus_oe     = active && ctl.drive && !abort;
    assign bus_dout   = !bus_oe      ? '0 :
                        !ctl.use_hold ? fifo_rdata :
                        ctl.sel_crc  ? crc_src : sgl_src;
    assign fifo_pop   = first && ctl.adv && !fifo_empty;
    assign fifo_push  = take && !ctl.use_hold && !fifo_full;
    assign fifo_wdata = fifo_push ? bus_din : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q    <= 1'b0;
            fifo_q  <= 1'b0;
            addr    <= '0;
            sgl_cap <= '0;
            crc_cap <= '0;
        end else begin
            if (start_ev) begin
                wr_q   <= wave_wr;
                fifo_q <= wave_fifo;
                addr   <= adr_init + AW'(nxt_incad);
            end else if (enter) begin
                addr   <= addr + AW'(nxt_incad);
            end
            if (take && ctl.use_hold) begin
                if (ctl.sel_crc) crc_cap <= bus_din;
                else             sgl_cap <= bus_din;
            end
        end
    end

    // R4
    adr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !first |-> $stable(addr));

    // R4
    adr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (first && $past(active)) |-> (addr == $past(addr) + AW'(op_incad)));

    // R9
    pop_dir_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (wr_q && !fifo_empty && !fifo_push));

    // R6
    oe_mode_chk: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (active && wr_q && !fifo_push));

    // R11
    abort_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        abort |-> (!bus_oe && !fifo_push ##1 !active));

endmodule

// File: rtl/wf_sequencer.sv
module wf_sequencer
    import wf_pkg::*;
#(
    parameter int NSTATE = 7,
    parameter int DW     = 16,
    parameter int AW     = 9,
    parameter int CW     = 8,
    localparam int STW   = $clog2(NSTATE + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  wave_wr,
    input  logic                  wave_fifo,
    input  logic [AW-1:0]         adr_init,
    input  logic [NSTATE*OPW-1:0] op_tbl,
    input  logic [NSTATE*CW-1:0]  dwell_tbl,
    input  logic [NSTATE*STW-1:0] hi_tbl,
    input  logic [NSTATE*STW-1:0] lo_tbl,
    input  logic                  ready,
    input  logic [DW-1:0]         fifo_rdata,
    input  logic                  fifo_empty,
    output logic                  fifo_pop,
    input  logic                  fifo_full,
    output logic                  fifo_push,
    output logic [DW-1:0]         fifo_wdata,
    input  logic [DW-1:0]         sgl_src,
    input  logic [DW-1:0]         crc_src,
    output logic [DW-1:0]         sgl_cap,
    output logic [DW-1:0]         crc_cap,
    input  logic [DW-1:0]         bus_din,
    output logic [DW-1:0]         bus_dout,
    output logic                  bus_oe,
    output logic [AW-1:0]         addr,
    output logic                  irq,
    output logic                  busy,
    output logic                  done
);

    wf_op_t         cur_op;
    logic [STW-1:0] state, nxt_idx, cur_hi, cur_lo;
    logic [CW-1:0]  nxt_dwell;
    logic           nxt_incad, first, leave, enter, abort;

    wf_opdec #(.NSTATE(NSTATE), .STW(STW), .CW(CW)) u_dec (
        .cur_idx(state), .nxt_idx(nxt_idx), .op_tbl(op_tbl),
        .dwell_tbl(dwell_tbl), .hi_tbl(hi_tbl), .lo_tbl(lo_tbl),
        .cur_op(cur_op), .cur_hi(cur_hi), .cur_lo(cur_lo),
        .nxt_dwell(nxt_dwell), .nxt_incad(nxt_incad)
    );

    wf_seq #(.NSTATE(NSTATE), .STW(STW), .CW(CW)) u_seq (
        .clk(clk), .rst(rst), .start(start), .ready(ready),
        .cur_dp(cur_op.dp), .cur_hi(cur_hi), .cur_lo(cur_lo),
        .nxt_dwell(nxt_dwell), .abort(abort), .state_q(state),
        .nxt_idx(nxt_idx), .first_q(first), .leave(leave),
        .enter(enter), .busy(busy), .done_q(done)
    );

    wf_dpath #(.DW(DW), .AW(AW)) u_dp (
        .clk(clk), .rst(rst), .start_ev(leave && !busy), .enter(enter),
        .first(first), .leave(leave), .active(busy),
        .op_sgl(cur_op.sgl), .op_gint(cur_op.gint), .op_incad(cur_op.incad),
        .op_nxt(cur_op.nxt), .op_data(cur_op.data), .nxt_incad(nxt_incad),
        .wave_wr(wave_wr), .wave_fifo(wave_fifo), .adr_init(adr_init),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .sgl_src(sgl_src), .crc_src(crc_src), .bus_din(bus_din),
        .abort(abort), .bus_oe(bus_oe), .bus_dout(bus_dout),
        .fifo_pop(fifo_pop), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .sgl_cap(sgl_cap), .crc_cap(crc_cap), .addr(addr), .irq(irq)
    );

endmodule

// File: tb/test_wf_sequencer.sv
module test_wf_sequencer;

    localparam int NS = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, wave_wr = 1'b0, wave_fifo = 1'b0, ready = 1'b0;
    logic [8:0]  adr_init = '0;
    logic [41:0] op_tbl;
    logic [55:0] dwell_tbl;
    logic [20:0] hi_tbl, lo_tbl;
    logic [15:0] fifo_rdata = '0, sgl_src = 16'h5A5A, crc_src = 16'hC3C3, bus_din = '0;
    logic        fifo_empty = 1'b1, fifo_full = 1'b0;
    logic        fifo_pop, fifo_push, bus_oe, irq, busy, done;
    logic [15:0] fifo_wdata, sgl_cap, crc_cap, bus_dout;
    logic [8:0]  addr;

    logic [5:0] op_m [NS];
    logic [7:0] dw_m [NS];
    logic [2:0] hi_m [NS];
    logic [2:0] lo_m [NS];

    always_comb begin
        for (int i = 0; i < NS; i++) begin
            op_tbl[i*6 +: 6]    = op_m[i];
            dwell_tbl[i*8 +: 8] = dw_m[i];
            hi_tbl[i*3 +: 3]    = hi_m[i];
            lo_tbl[i*3 +: 3]    = lo_m[i];
        end
    end

    always #10ns clk = ~clk;

    wf_sequencer i_wf_sequencer (
        .clk(clk), .rst(rst), .start(start), .wave_wr(wave_wr), .wave_fifo(wave_fifo),
        .adr_init(adr_init), .op_tbl(op_tbl), .dwell_tbl(dwell_tbl), .hi_tbl(hi_tbl),
        .lo_tbl(lo_tbl), .ready(ready), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .fifo_full(fifo_full), .fifo_push(fifo_push),
        .fifo_wdata(fifo_wdata), .sgl_src(sgl_src), .crc_src(crc_src), .sgl_cap(sgl_cap),
        .crc_cap(crc_cap), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .addr(addr), .irq(irq), .busy(busy), .done(done)
    );

    int n_chk = 0, n_bad = 0;

    // reference model state
    int          mst = 7, mcnt = 0, rcap = 4;
    bit          mfirst = 0, mdone = 0, mwr = 0, mfifo = 0;
    logic [8:0]  maddr = '0;
    logic [15:0] msgl = '0, mcrc = '0;
    logic [15:0] wq[$], rq[$];
    string       btag = "R1", dtag = "R10";

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R12 opcode layout: sgl[5] gint[4] incad[3] nxt[2] data[1] dp[0]
    function automatic logic [5:0] mk(bit sg, bit gi, bit ic, bit nx, bit da, bit dp);
        return {sg, gi, ic, nx, da, dp};
    endfunction

    task automatic refresh();
        fifo_empty = (wq.size() == 0);
        fifo_rdata = (wq.size() != 0) ? wq[0] : 16'h0;
        fifo_full  = (rq.size() >= rcap);
    endtask

    task automatic step();
        bit act, sg, gi, nx, da, dp, uh, sc, ab, lv, e_oe, e_pop, e_push, take;
        logic [5:0]  o;
        logic [15:0] e_dout;
        int nst, t;
        #2;
        act = (mst != 7);
        o   = act ? op_m[mst] : 6'h0;
        sg = o[5]; gi = o[4]; nx = o[2]; da = o[1]; dp = o[0];
        uh = !mfifo || sg;
        sc = mfifo && sg && nx;
        ab = act && mfirst && mfifo && !sg && da && (mwr ? fifo_empty : fifo_full);
        nst = mst; lv = 0;
        if (!act) begin
            if (start) begin nst = 0; lv = 1; end
        end else if (ab) begin
            nst = 7; lv = 1;
        end else if (dp) begin
            t = ready ? hi_m[mst] : lo_m[mst];
            if (t != mst) begin nst = t; lv = 1; end
        end else if (mcnt == 0) begin
            nst = mst + 1; lv = 1;
        end
        e_oe   = act && mwr && da && !ab;
        e_dout = !e_oe ? 16'h0 : !uh ? (wq.size() != 0 ? wq[0] : 16'h0) : sc ? crc_src : sgl_src;
        e_pop  = act && mfirst && mfifo && !sg && nx && mwr && (wq.size() != 0);
        take   = act && lv && !ab && !mwr && da;
        e_push = take && !uh && (rq.size() < rcap);

        chk(btag, busy, act);
        chk("R4 addr", addr, maddr);
        chk("R5 irq", irq, mfirst && gi);
        chk("R6 bus_oe", bus_oe, e_oe);
        chk("R6 bus_dout", bus_dout, e_dout);
        chk("R9 R12 fifo_pop", fifo_pop, e_pop);
        chk("R7 fifo_push", fifo_push, e_push);
        chk("R7 fifo_wdata", fifo_wdata, e_push ? bus_din : 16'h0);
        chk("R8 sgl_cap", sgl_cap, msgl);
        chk("R8 crc_cap", crc_cap, mcrc);
        chk(dtag, done, mdone);

        @(posedge clk);
        #1;
        if (e_pop)  void'(wq.pop_front());
        if (e_push) rq.push_back(bus_din);
        if (take && uh) begin
            if (sc) mcrc = bus_din;
            else    msgl = bus_din;
        end
        if (!act && lv) begin
            maddr = adr_init + 9'(op_m[0][3]);
            mwr = wave_wr; mfifo = wave_fifo;
        end else if (lv && nst != 7) begin
            maddr = maddr + 9'(op_m[nst][3]);
        end
        if (lv && nst != 7)      mcnt = dw_m[nst];
        else if (act && mcnt > 0) mcnt--;
        mdone  = act && lv && (nst == 7);
        dtag   = ab ? "R11 done" : "R10 done";
        mfirst = lv && (nst != 7);
        btag   = !act ? "R1 busy" : ab ? "R11 busy" : dp ? "R3 busy" : "R2 busy";
        mst    = nst;
        refresh();
        @(negedge clk);
    endtask

    task automatic run(bit wr, bit fifo, logic [8:0] base, int nw, int cap, int pat, int ncyc);
        wave_wr = wr; wave_fifo = fifo; adr_init = base;
        wq.delete(); rq.delete(); rcap = cap;
        for (int i = 0; i < nw; i++) wq.push_back(16'hA000 + 16'(i * 16'h0111));
        refresh();
        for (int c = 0; c < ncyc; c++) begin
            start   = (c == 0) || (c == 5);
            ready   = (c % pat) == 0;
            bus_din = 16'h3C00 ^ 16'(c * 16'h0105);
            step();
        end
        start = 1'b0;
    endtask

    task automatic table_a();
        op_m[0] = mk(0,1,1,1,1,0); dw_m[0] = 8'd2; hi_m[0] = 3'd0; lo_m[0] = 3'd0;
        op_m[1] = mk(0,0,0,0,1,1); dw_m[1] = 8'd0; hi_m[1] = 3'd2; lo_m[1] = 3'd1;
        op_m[2] = mk(1,0,1,1,1,0); dw_m[2] = 8'd1; hi_m[2] = 3'd0; lo_m[2] = 3'd0;
        op_m[3] = mk(1,1,0,0,1,0); dw_m[3] = 8'd0; hi_m[3] = 3'd0; lo_m[3] = 3'd0;
        op_m[4] = mk(0,0,1,1,1,0); dw_m[4] = 8'd0; hi_m[4] = 3'd0; lo_m[4] = 3'd0;
        op_m[5] = mk(0,1,0,0,0,1); dw_m[5] = 8'd0; hi_m[5] = 3'd0; lo_m[5] = 3'd6;
        op_m[6] = mk(0,0,1,0,0,0); dw_m[6] = 8'd3; hi_m[6] = 3'd0; lo_m[6] = 3'd0;
    endtask

    initial begin
        #3ms;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        table_a();
        refresh();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 reset busy", busy, 0);
        chk("R1 reset addr", addr, 0);
        chk("R10 reset done", done, 0);
        chk("R6 reset bus_oe", bus_oe, 0);
        step(); step();

        // FIFO write, ready every cycle: loops back and drains the FIFO (R11)
        run(1, 1, 9'h010, 6, 4, 1, 80);
        // FIFO write, slow ready, address wrap (R4)
        sgl_src = 16'h1234; crc_src = 16'hBEEF;
        run(1, 1, 9'h1FE, 12, 4, 3, 90);
        // FIFO read, small inbound FIFO: fills and aborts (R11)
        run(0, 1, 9'h020, 0, 2, 1, 80);
        // FIFO read, roomy inbound FIFO, slow ready
        run(0, 1, 9'h030, 0, 16, 2, 90);
        // single write and read: sgl ignored, no FIFO traffic (R8)
        run(1, 0, 9'h040, 3, 4, 1, 60);
        run(0, 0, 9'h050, 0, 0, 2, 60);

        // linear table with no decision points (R2, R10)
        for (int i = 0; i < NS; i++) begin
            op_m[i] = mk(i[0], i[1], 1, 0, 1, 0);
            dw_m[i] = 8'(i);
        end
        run(0, 1, 9'h100, 0, 8, 1, 50);
        run(1, 1, 9'h100, 8, 8, 1, 50);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule